// File: doc/BRIEF.md
# Accumulator ALU with Opcode Decode

This block is the arithmetic and logic stage of a small accumulator machine. It takes the current accumulator value, one operand word fetched from memory and the 3-bit operation code of the instruction being executed. From these it forms the word that the accumulator loads next, and a flag that reports whether the accumulator is zero.

Only four operation codes compute anything: add, bitwise AND, bitwise XOR and a load that forwards the memory word. Every other code returns the accumulator unchanged, so the surrounding control can load the accumulator on every instruction without corrupting it. The zero flag always describes the accumulator input, never the result. The conditional skip instruction tests this flag.

The block holds no state and has no clock, so every output follows its inputs combinationally. The stream-style valid/ready handshake does not apply here, because nothing is buffered and nothing can stall.

Top module: `acc_alu`

## Requirements
- R1: Operation code 3'b010 (add) drives the result with the accumulator plus the memory word modulo 2^DATA_W. Any carry out of the top bit is dropped.
- R2: Operation code 3'b011 (and) drives the result with the bitwise AND of the accumulator and the memory word.
- R3: Operation code 3'b100 (xor) drives the result with the bitwise XOR of the accumulator and the memory word.
- R4: Operation code 3'b101 (load) drives the result with the memory word unchanged, whatever the accumulator holds.
- R5: Operation codes 3'b000 (halt), 3'b001 (skip if zero), 3'b110 (store) and 3'b111 (jump) drive the result with the accumulator unchanged, whatever the memory word holds.
- R6: The zero flag is 1 exactly when the accumulator input is all zeros. The operation code and the memory word have no effect on it.
- R7: Both outputs are combinational. A change on any input appears at the outputs with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mem_word_i | input | DATA_W (8) | Operand word read from memory |
| acc_i | input | DATA_W (8) | Current accumulator value |
| opcode_i | input | 3 | Operation code of the current instruction |
| result_o | output | DATA_W (8) | Next value for the accumulator |
| acc_zero_o | output | 1 | 1 when acc_i is all zeros |

## Verification
Both results are due in the same cycle as the stimulus, with zero cycles of latency. The bench drives a new operand set just after each rising edge of its clock and compares both outputs with its behavioural model at the following falling edge. For R7 it also changes the inputs in the middle of a cycle, waits one time unit and checks again before any clock edge arrives. The stimulus includes the wrap of the sum at the top value, all-zero and all-one operands, and every operation code paired with a zero and a non-zero accumulator.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int OP_W = 3;

  typedef enum logic [OP_W-1:0] {
    OP_HALT  = 3'b000,
    OP_SKIPZ = 3'b001,
    OP_ADD   = 3'b010,
    OP_AND   = 3'b011,
    OP_XOR   = 3'b100,
    OP_LOAD  = 3'b101,
    OP_STORE = 3'b110,
    OP_JUMP  = 3'b111
  } op_e;

  typedef enum logic [1:0] {
    SEL_ACC  = 2'd0,
    SEL_SUM  = 2'd1,
    SEL_BIT  = 2'd2,
    SEL_MEM  = 2'd3
  } sel_e;
endpackage

// File: rtl/acc_op_decode.sv
module acc_op_decode
  import acc_alu_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output sel_e            sel_o,
  output logic            bit_xor_o
);
  op_e op;
  assign op = op_e'(opcode_i);

  always_comb begin
    sel_o     = SEL_ACC;
    bit_xor_o = 1'b0;
    unique case (op)
      OP_ADD:  sel_o = SEL_SUM;
      OP_AND:  sel_o = SEL_BIT;
      OP_XOR: begin
        sel_o     = SEL_BIT;
        bit_xor_o = 1'b1;
      end
      OP_LOAD: sel_o = SEL_MEM;
      default: sel_o = SEL_ACC;
    endcase
  end
endmodule

// File: rtl/acc_bitwise.sv
module acc_bitwise #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              xor_i,
  output logic [DATA_W-1:0] y_o
);
  for (genvar g = 0; g < DATA_W; g++) begin : g_bit
    assign y_o[g] = xor_i ? (a_i[g] ^ b_i[g]) : (a_i[g] & b_i[g]);
  end
endmodule

// File: rtl/acc_adder.sv
module acc_adder #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic [DATA_W-1:0] sum_o
);
  logic [DATA_W:0] carry;
  assign carry[0] = 1'b0;

  for (genvar g = 0; g < DATA_W; g++) begin : g_ripple
    assign sum_o[g]   = a_i[g] ^ b_i[g] ^ carry[g];
    assign carry[g+1] = (a_i[g] & b_i[g]) | (carry[g] & (a_i[g] ^ b_i[g]));
  end

  logic carry_unused;
  assign carry_unused = carry[DATA_W];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] mem_word_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [OP_W-1:0]   opcode_i,
  output logic [DATA_W-1:0] result_o,
  output logic              acc_zero_o
);
  sel_e              sel;
  logic              bit_xor;
  logic [DATA_W-1:0] sum;
  logic [DATA_W-1:0] bits;

  acc_op_decode u_dec (
    .opcode_i  (opcode_i),
    .sel_o     (sel),
    .bit_xor_o (bit_xor)
  );

  acc_adder #(.DATA_W(DATA_W)) u_add (
    .a_i   (acc_i),
    .b_i   (mem_word_i),
    .sum_o (sum)
  );

  acc_bitwise #(.DATA_W(DATA_W)) u_bit (
    .a_i   (acc_i),
    .b_i   (mem_word_i),
    .xor_i (bit_xor),
    .y_o   (bits)
  );

  always_comb begin
    unique case (sel)
      SEL_SUM: result_o = sum;
      SEL_BIT: result_o = bits;
      SEL_MEM: result_o = mem_word_i;
      default: result_o = acc_i;
    endcase
  end

  assign acc_zero_o = ~|acc_i;
endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker #(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] mem_word_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [2:0]        opcode_i,
  input logic [DATA_W-1:0] result_o,
  input logic              acc_zero_o
);
  logic [DATA_W-1:0] diff;
  assign diff = result_o - acc_i;

  always_comb begin
    if (opcode_i == 3'b010)
      assert_add_wraps_R1: assert (diff == mem_word_i);
    if (opcode_i == 3'b011)
      assert_and_subset_R2: assert (((result_o & ~acc_i) | (result_o & ~mem_word_i)
                                     | ((acc_i & mem_word_i) & ~result_o)) == '0);
    if (opcode_i == 3'b100)
      assert_xor_inverts_R3: assert ((result_o ^ acc_i) == mem_word_i);
    if (opcode_i == 3'b101)
      assert_load_forwards_R4: assert (result_o == mem_word_i);
    if (opcode_i == 3'b000 || opcode_i == 3'b001 || opcode_i == 3'b110 || opcode_i == 3'b111)
      assert_pass_keeps_acc_R5: assert (result_o == acc_i);
    if (acc_zero_o)
      assert_zero_means_empty_R6: assert (acc_i == '0);
    if (acc_i == '0)
      assert_empty_sets_zero_R6: assert (acc_zero_o);
  end
endmodule

bind acc_alu acc_alu_checker #(.DATA_W(DATA_W)) u_acc_alu_checker (
  .mem_word_i (mem_word_i),
  .acc_i      (acc_i),
  .opcode_i   (opcode_i),
  .result_o   (result_o),
  .acc_zero_o (acc_zero_o)
);

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic [W-1:0] mem_word = '0;
  logic [W-1:0] acc = '0;
  logic [2:0]   opc = 3'b000;
  logic [W-1:0] result;
  logic         acc_zero;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  acc_alu #(.DATA_W(W)) dut_i (
    .mem_word_i (mem_word),
    .acc_i      (acc),
    .opcode_i   (opc),
    .result_o   (result),
    .acc_zero_o (acc_zero)
  );

  function automatic int model_result(int op, int a, int m);
    case (op)
      2: return (a + m) % 256;
      3: return a & m;
      4: return a ^ m;
      5: return m;
      default: return a;
    endcase
  endfunction

  function automatic string tag_of(int op);
    case (op)
      2: return "R1";
      3: return "R2";
      4: return "R3";
      5: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic compare(string ctx);
    int exp_r;
    int exp_z;
    exp_r = model_result(int'(opc), int'(acc), int'(mem_word));
    exp_z = (acc == 0) ? 1 : 0;
    n_checks++;
    if (int'(result) != exp_r) begin
      n_fails++;
      $display("FAIL %s %s op=%0d acc=%0h mem=%0h: result actual %0h expected %0h",
               tag_of(int'(opc)), ctx, opc, acc, mem_word, result, exp_r);
    end
    n_checks++;
    if (int'(acc_zero) != exp_z) begin
      n_fails++;
      $display("FAIL R6 %s op=%0d acc=%0h: zero actual %0d expected %0d",
               ctx, opc, acc, acc_zero, exp_z);
    end
  endtask

  task automatic apply(int op, int a, int m, string ctx);
    @(posedge clk);
    #0.5;
    opc = 3'(op);
    acc = 8'(a);
    mem_word = 8'(m);
    @(negedge clk);
    compare(ctx);
  endtask

  initial begin
    int lfsr;
    #1;
    compare("idle inputs");
    apply(2, 8'hFF, 8'h01, "R1 wrap");
    apply(2, 8'h80, 8'h80, "R1 wrap high");
    apply(2, 8'h12, 8'h34, "R1 plain");
    apply(3, 8'hF0, 8'h3C, "R2 mask");
    apply(3, 8'hFF, 8'h00, "R2 zero mem");
    apply(4, 8'hAA, 8'hFF, "R3 invert");
    apply(4, 8'h5A, 8'h5A, "R3 self");
    apply(5, 8'h77, 8'h90, "R4 load");
    apply(5, 8'h00, 8'h00, "R4 load zero");
    for (int op = 0; op < 8; op++) begin
      apply(op, 8'h00, 8'hC3, "R6 acc zero");
      apply(op, 8'h01, 8'h00, "R6 acc nonzero");
    end
    apply(0, 8'h9D, 8'h42, "R5 halt");
    apply(1, 8'h00, 8'hFF, "R5 skip");
    apply(6, 8'h3E, 8'h11, "R5 store");
    apply(7, 8'hE1, 8'h07, "R5 jump");
    // R7: mid-cycle change, checked before the next edge
    @(negedge clk);
    opc = 3'b010; acc = 8'h0F; mem_word = 8'hF1;
    #1;
    compare("R7 no clock add");
    opc = 3'b101; mem_word = 8'h00;
    #1;
    compare("R7 no clock load");
    acc = 8'h00;
    #0.5;
    compare("R7 no clock zero");
    lfsr = 32'h1ACE;
    for (int i = 0; i < 600; i++) begin
      lfsr = ((lfsr << 1) | (((lfsr >> 15) ^ (lfsr >> 13) ^ (lfsr >> 12) ^ (lfsr >> 10)) & 1)) & 32'hFFFF;
      apply(lfsr & 7, (lfsr >> 3) & 8'hFF, (lfsr >> 8) & 8'hFF, "sweep");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule